// File: doc/BRIEF.md
# Mailbox Ring Scanner

This block is the adapter-side engine of a host/adapter mailbox interface. The host keeps two rings of equal length in its own memory: an outgoing ring of request entries starting at a base address, and an incoming ring of completion entries placed directly after it. The host sets the ring length, base address and entry format with an initialisation command, fills outgoing entries, and then rings a doorbell. The scanner walks the outgoing ring, hands each taken control block pointer to a command-execution stage, and frees the entry.

When the execution stage reports a finished control block, the scanner writes a completion entry into the next incoming slot and raises the incoming-loaded interrupt. Two entry formats are supported. The narrow format is a 4-byte entry with the pointer stored most significant byte first. The wide format is an 8-byte entry with the pointer stored least significant byte first. All memory traffic is one byte per request on a simple request/acknowledge port.

Top module: `mbox_ring_scanner`

## Requirements
- R1: Command byte 0x01 followed by a count byte and three base bytes (most significant first) selects the 4-byte entry format with base bits 31:24 zero. It sets the outgoing index to 0 and the incoming index to the count.
- R2: Command byte 0x81 followed by a count byte and four base bytes (least significant first) selects the 8-byte entry format. Entries in both formats are then read, freed and posted at their format's offsets.
- R3: A doorbell (command byte 0x02) received before any initialisation causes no memory request. Unknown command bytes are ignored.
- R4: After a doorbell, outgoing entries are read in index order until one holds code 0x00. That entry is not written, and the index stays on it. No further entry is read until the next doorbell.
- R5: For a taken entry, the pointer is assembled and the code byte is rewritten to 0x00. The pointer is at offsets 1..3 most significant first in the narrow format, or offsets 0..3 least significant first in the wide format. The code byte is at offset 0 (narrow) or offset 7 (wide). In the cycle after that write is acknowledged, exec_valid pulses for one cycle with the pointer, and exec_abort is 1 for code 0x02 and 0 for code 0x01.
- R6: A taken entry with a nonzero code other than 0x01 or 0x02 is freed, but produces no exec_valid pulse.
- R7: Entry n of either ring sits at base + n x entry size. The outgoing index wraps from N-1 to 0.
- R8: A completion is accepted when cmpl_valid and cmpl_ready are both high, and it is held in a single slot. cmpl_ready is low from the next cycle until that completion has been posted.
- R9: A completion goes to incoming index I, which runs from N to 2N-1 and wraps back to N. All other bytes are written first: in the narrow format the pointer at offsets 1..3, most significant first; in the wide format the pointer at offsets 0..3 least significant first, adapter status at 4, device status at 5, and 0x00 at 6. The code byte is written last.
- R10: If the code byte of the target incoming entry is nonzero, no byte of that entry is written. The check is repeated until the host clears the entry.
- R11: irq_loaded rises in the cycle after the completion code write is acknowledged. It stays high until irq_clr; a new posting in the same cycle as irq_clr wins.
- R12: A memory request keeps mem_req, mem_addr, mem_we and mem_wdata stable until mem_ack, and it moves one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command or parameter byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request done; read byte valid |
| mem_rdata | input | 8 | Read byte |
| exec_valid | output | 1 | One-cycle pulse: control block handed over |
| exec_abort | output | 1 | 1 = abort request, 0 = start request |
| exec_ptr | output | PW | Control block pointer |
| cmpl_valid | input | 1 | Completion offered |
| cmpl_ready | output | 1 | Completion slot free |
| cmpl_ptr | input | PW | Pointer of finished control block |
| cmpl_code | input | 8 | Completion code (0x01..0x04) |
| cmpl_hstat | input | 8 | Adapter status (wide format only) |
| cmpl_dstat | input | 8 | Device status (wide format only) |
| irq_loaded | output | 1 | Incoming-loaded interrupt |
| irq_clr | input | 1 | Clears irq_loaded |

## Verification
A command byte takes effect one cycle after its strobe. Each memory byte costs at least two cycles, paced entirely by mem_ack. exec_valid is due exactly one cycle after the freeing write is acknowledged, irq_loaded one cycle after the code write is acknowledged, and cmpl_ready falls one cycle after acceptance. The bench therefore compares exec pulses in a monitor at the falling edge whenever they appear, against a queue of expected hand-overs filled when the entries are planted. It checks memory contents and irq_loaded only after a window long enough for the slowed bench memory to finish, and its memory model checks request stability on every wait state.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam logic [7:0] OP_INIT_NARROW = 8'h01;
    localparam logic [7:0] OP_DOORBELL    = 8'h02;
    localparam logic [7:0] OP_INIT_WIDE   = 8'h81;

    localparam logic [7:0] ACT_FREE  = 8'h00;
    localparam logic [7:0] ACT_START = 8'h01;
    localparam logic [7:0] ACT_ABORT = 8'h02;

    localparam int NARROW_PARAMS = 4;
    localparam int WIDE_PARAMS   = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OCODE,
        S_OPTR,
        S_OFREE,
        S_ICHK,
        S_IWR,
        S_ICODE
    } scan_st_e;
endpackage

// File: rtl/msr_cmd_dec.sv
module msr_cmd_dec
    import msr_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_byte,
    output logic          init_valid,
    output logic          init_wide,
    output logic [CW-1:0] init_count,
    output logic [AW-1:0] init_base,
    output logic          doorbell
);
    typedef struct packed {
        logic          busy;
        logic          wide;
        logic [2:0]    left;
        logic [2:0]    pos;
        logic [CW-1:0] cnt;
        logic [AW-1:0] base;
        logic          init_v;
        logic          bell;
    } dec_t;

    dec_t dec_q, dec_d;

    always_comb begin
        dec_d        = dec_q;
        dec_d.init_v = 1'b0;
        dec_d.bell   = 1'b0;
        if (cmd_valid) begin
            if (!dec_q.busy) begin
                case (cmd_byte)
                    OP_INIT_NARROW: begin
                        dec_d.busy = 1'b1;
                        dec_d.wide = 1'b0;
                        dec_d.left = 3'(NARROW_PARAMS);
                        dec_d.pos  = 3'd0;
                        dec_d.base = '0;
                    end
                    OP_INIT_WIDE: begin
                        dec_d.busy = 1'b1;
                        dec_d.wide = 1'b1;
                        dec_d.left = 3'(WIDE_PARAMS);
                        dec_d.pos  = 3'd0;
                        dec_d.base = '0;
                    end
                    OP_DOORBELL: dec_d.bell = 1'b1;
                    default: ;
                endcase
            end else begin
                if (dec_q.pos == 3'd0) begin
                    dec_d.cnt = CW'(cmd_byte);
                end else if (dec_q.wide) begin
                    dec_d.base = dec_q.base | (AW'(cmd_byte) << (8 * (dec_q.pos - 3'd1)));
                end else begin
                    dec_d.base = {dec_q.base[AW-9:0], cmd_byte};
                end
                dec_d.pos  = dec_q.pos + 3'd1;
                dec_d.left = dec_q.left - 3'd1;
                if (dec_q.left == 3'd1) begin
                    dec_d.busy   = 1'b0;
                    dec_d.init_v = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign init_valid = dec_q.init_v;
    assign init_wide  = dec_q.wide;
    assign init_count = dec_q.cnt;
    assign init_base  = dec_q.base;
    assign doorbell   = dec_q.bell;

    // an init needs at least four parameter bytes, so its pulse never repeats
    p_init_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        init_valid |=> !init_valid);
endmodule

// File: rtl/msr_addr.sv
module msr_addr #(
    parameter int AW = 32,
    parameter int IW = 9
) (
    input  logic [AW-1:0] base_i,
    input  logic [IW-1:0] idx_i,
    input  logic          wide_i,
    input  logic [2:0]    off_i,
    output logic [AW-1:0] addr_o
);
    localparam int SH_NARROW = 2;
    localparam int SH_WIDE   = 3;

    logic [AW-1:0] slot;

    always_comb begin
        slot   = AW'(idx_i) << (wide_i ? SH_WIDE : SH_NARROW);
        addr_o = base_i + slot + AW'(off_i);
    end
endmodule

// File: rtl/msr_engine.sv
module msr_engine
    import msr_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 8,
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_valid,
    input  logic          init_wide,
    input  logic [CW-1:0] init_count,
    input  logic [AW-1:0] init_base,
    input  logic          doorbell,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic          mem_ack,
    input  logic [7:0]    mem_rdata,
    output logic          exec_valid,
    output logic          exec_abort,
    output logic [PW-1:0] exec_ptr,
    input  logic          cmpl_valid,
    output logic          cmpl_ready,
    input  logic [PW-1:0] cmpl_ptr,
    input  logic [7:0]    cmpl_code,
    input  logic [7:0]    cmpl_hstat,
    input  logic [7:0]    cmpl_dstat,
    output logic          irq_loaded,
    input  logic          irq_clr
);
    localparam int IW = CW + 1;

    typedef struct packed {
        scan_st_e      st;
        logic [2:0]    cnt;
        logic [7:0]    code;
        logic [PW-1:0] ptr;
        logic [IW-1:0] oidx;
        logic [IW-1:0] iidx;
        logic          scan;
        logic          hfull;
        logic [PW-1:0] hptr;
        logic [7:0]    hcode;
        logic [7:0]    hhs;
        logic [7:0]    hds;
        logic          ev;
        logic          eab;
        logic [PW-1:0] eptr;
        logic          irq;
        logic          wide;
        logic [CW-1:0] n;
        logic [AW-1:0] base;
        logic          cfg;
    } eng_t;

    eng_t eng_q, eng_d;

    logic [IW-1:0] acc_idx;
    logic [2:0]    acc_off;
    logic [7:0]    acc_wdata;
    logic          acc_req;
    logic          acc_we;
    logic [2:0]    code_pos;
    logic [2:0]    ptr_last;
    logic [2:0]    iwr_last;
    logic [7:0]    iwr_byte;
    logic [IW-1:0] out_last;
    logic [IW-1:0] in_last;

    assign code_pos = eng_q.wide ? 3'd7 : 3'd0;
    assign ptr_last = eng_q.wide ? 3'd3 : 3'd2;
    assign iwr_last = eng_q.wide ? 3'd6 : 3'd2;
    assign out_last = IW'(eng_q.n) - IW'(1);
    assign in_last  = {eng_q.n, 1'b0} - IW'(1);

    // byte written during the body of an incoming entry
    always_comb begin
        if (eng_q.wide) begin
            case (eng_q.cnt)
                3'd0, 3'd1, 3'd2, 3'd3: iwr_byte = eng_q.hptr[8*eng_q.cnt +: 8];
                3'd4:                   iwr_byte = eng_q.hhs;
                3'd5:                   iwr_byte = eng_q.hds;
                default:                iwr_byte = 8'h00;
            endcase
        end else begin
            iwr_byte = eng_q.hptr[8*(3'd2 - eng_q.cnt) +: 8];
        end
    end

    // memory access selected by the current state
    always_comb begin
        acc_idx   = eng_q.oidx;
        acc_off   = code_pos;
        acc_req   = 1'b0;
        acc_we    = 1'b0;
        acc_wdata = 8'h00;
        case (eng_q.st)
            S_OCODE: acc_req = 1'b1;
            S_OPTR: begin
                acc_req = 1'b1;
                acc_off = eng_q.wide ? eng_q.cnt : eng_q.cnt + 3'd1;
            end
            S_OFREE: begin
                acc_req = 1'b1;
                acc_we  = 1'b1;
            end
            S_ICHK: begin
                acc_req = 1'b1;
                acc_idx = eng_q.iidx;
            end
            S_IWR: begin
                acc_req   = 1'b1;
                acc_we    = 1'b1;
                acc_idx   = eng_q.iidx;
                acc_off   = eng_q.wide ? eng_q.cnt : eng_q.cnt + 3'd1;
                acc_wdata = iwr_byte;
            end
            S_ICODE: begin
                acc_req   = 1'b1;
                acc_we    = 1'b1;
                acc_idx   = eng_q.iidx;
                acc_wdata = eng_q.hcode;
            end
            default: ;
        endcase
    end

    msr_addr #(.AW(AW), .IW(IW)) u_addr (
        .base_i (eng_q.base),
        .idx_i  (acc_idx),
        .wide_i (eng_q.wide),
        .off_i  (acc_off),
        .addr_o (mem_addr)
    );

    always_comb begin
        eng_d    = eng_q;
        eng_d.ev = 1'b0;
        if (irq_clr) eng_d.irq = 1'b0;
        if (doorbell && eng_q.cfg) eng_d.scan = 1'b1;
        if (cmpl_valid && !eng_q.hfull) begin
            eng_d.hfull = 1'b1;
            eng_d.hptr  = cmpl_ptr;
            eng_d.hcode = cmpl_code;
            eng_d.hhs   = cmpl_hstat;
            eng_d.hds   = cmpl_dstat;
        end
        case (eng_q.st)
            S_IDLE: begin
                if (eng_q.scan)                    eng_d.st = S_OCODE;
                else if (eng_q.hfull && eng_q.cfg) eng_d.st = S_ICHK;
            end
            S_OCODE: if (mem_ack) begin
                if (mem_rdata == ACT_FREE) begin
                    eng_d.st   = S_IDLE;
                    eng_d.scan = doorbell;
                end else begin
                    eng_d.code = mem_rdata;
                    eng_d.cnt  = 3'd0;
                    eng_d.ptr  = '0;
                    eng_d.st   = S_OPTR;
                end
            end
            S_OPTR: if (mem_ack) begin
                if (eng_q.wide) eng_d.ptr = eng_q.ptr | (PW'(mem_rdata) << (8 * eng_q.cnt));
                else            eng_d.ptr = {eng_q.ptr[PW-9:0], mem_rdata};
                if (eng_q.cnt == ptr_last) eng_d.st  = S_OFREE;
                else                       eng_d.cnt = eng_q.cnt + 3'd1;
            end
            S_OFREE: if (mem_ack) begin
                eng_d.ev   = (eng_q.code == ACT_START) || (eng_q.code == ACT_ABORT);
                eng_d.eab  = (eng_q.code == ACT_ABORT);
                eng_d.eptr = eng_q.ptr;
                eng_d.oidx = (eng_q.oidx == out_last) ? '0 : eng_q.oidx + IW'(1);
                eng_d.st   = S_IDLE;
            end
            S_ICHK: if (mem_ack) begin
                if (mem_rdata != 8'h00) begin
                    eng_d.st = S_IDLE;
                end else begin
                    eng_d.cnt = 3'd0;
                    eng_d.st  = S_IWR;
                end
            end
            S_IWR: if (mem_ack) begin
                if (eng_q.cnt == iwr_last) eng_d.st  = S_ICODE;
                else                       eng_d.cnt = eng_q.cnt + 3'd1;
            end
            S_ICODE: if (mem_ack) begin
                eng_d.irq   = 1'b1;
                eng_d.hfull = 1'b0;
                eng_d.iidx  = (eng_q.iidx == in_last) ? IW'(eng_q.n) : eng_q.iidx + IW'(1);
                eng_d.st    = S_IDLE;
            end
            default: eng_d.st = S_IDLE;
        endcase
        if (init_valid) begin
            eng_d.st   = S_IDLE;
            eng_d.cfg  = 1'b1;
            eng_d.wide = init_wide;
            eng_d.n    = init_count;
            eng_d.base = init_base;
            eng_d.oidx = '0;
            eng_d.iidx = IW'(init_count);
            eng_d.scan = 1'b0;
            eng_d.cnt  = 3'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign mem_req    = acc_req;
    assign mem_we     = acc_we;
    assign mem_wdata  = acc_wdata;
    assign exec_valid = eng_q.ev;
    assign exec_abort = eng_q.eab;
    assign exec_ptr   = eng_q.eptr;
    assign cmpl_ready = !eng_q.hfull;
    assign irq_loaded = eng_q.irq;

    p_req_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    p_exec_after_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> $past(mem_req && mem_ack && mem_we && (mem_wdata == 8'h00)));

    p_irq_after_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_loaded) |-> $past(eng_q.st == S_ICODE && mem_ack));

    p_single_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid && cmpl_ready |=> !cmpl_ready);

    p_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.cfg |-> (eng_q.iidx >= IW'(eng_q.n)) && (eng_q.iidx < {eng_q.n, 1'b0}));

    p_out_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.cfg |-> eng_q.oidx < IW'(eng_q.n));

    p_no_pre_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_q.cfg |-> !mem_req);
endmodule

// File: rtl/mbox_ring_scanner.sv
module mbox_ring_scanner #(
    parameter int AW = 32,
    parameter int CW = 8,
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_byte,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic          mem_ack,
    input  logic [7:0]    mem_rdata,
    output logic          exec_valid,
    output logic          exec_abort,
    output logic [PW-1:0] exec_ptr,
    input  logic          cmpl_valid,
    output logic          cmpl_ready,
    input  logic [PW-1:0] cmpl_ptr,
    input  logic [7:0]    cmpl_code,
    input  logic [7:0]    cmpl_hstat,
    input  logic [7:0]    cmpl_dstat,
    output logic          irq_loaded,
    input  logic          irq_clr
);
    logic          init_valid;
    logic          init_wide;
    logic [CW-1:0] init_count;
    logic [AW-1:0] init_base;
    logic          doorbell;

    msr_cmd_dec #(.AW(AW), .CW(CW)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .init_valid (init_valid),
        .init_wide  (init_wide),
        .init_count (init_count),
        .init_base  (init_base),
        .doorbell   (doorbell)
    );

    msr_engine #(.AW(AW), .CW(CW), .PW(PW)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_valid (init_valid),
        .init_wide  (init_wide),
        .init_count (init_count),
        .init_base  (init_base),
        .doorbell   (doorbell),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .exec_valid (exec_valid),
        .exec_abort (exec_abort),
        .exec_ptr   (exec_ptr),
        .cmpl_valid (cmpl_valid),
        .cmpl_ready (cmpl_ready),
        .cmpl_ptr   (cmpl_ptr),
        .cmpl_code  (cmpl_code),
        .cmpl_hstat (cmpl_hstat),
        .cmpl_dstat (cmpl_dstat),
        .irq_loaded (irq_loaded),
        .irq_clr    (irq_clr)
    );
endmodule

// File: tb/mbox_ring_scanner_bench.sv
module mbox_ring_scanner_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic        exec_valid;
    logic        exec_abort;
    logic [31:0] exec_ptr;
    logic        cmpl_valid = 1'b0;
    logic        cmpl_ready;
    logic [31:0] cmpl_ptr = '0;
    logic [7:0]  cmpl_code = '0;
    logic [7:0]  cmpl_hstat = '0;
    logic [7:0]  cmpl_dstat = '0;
    logic        irq_loaded;
    logic        irq_clr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_ring_scanner u_mbox_ring_scanner (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .exec_valid(exec_valid), .exec_abort(exec_abort), .exec_ptr(exec_ptr),
        .cmpl_valid(cmpl_valid), .cmpl_ready(cmpl_ready), .cmpl_ptr(cmpl_ptr),
        .cmpl_code(cmpl_code), .cmpl_hstat(cmpl_hstat), .cmpl_dstat(cmpl_dstat),
        .irq_loaded(irq_loaded), .irq_clr(irq_clr)
    );

    typedef struct {
        logic [31:0] ptr;
        logic        ab;
    } exp_t;

    exp_t        q_exp[$];
    logic [7:0]  mem [0:1023];
    int          n_checks = 0;
    int          n_err = 0;
    int          n_req = 0;
    logic [31:0] last_wr = '0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // slowed memory: one wait state per request, stability checked on it (R12)
    task automatic mem_model();
        logic        seen = 1'b0;
        logic [31:0] a0 = '0;
        logic        w0 = 1'b0;
        logic [7:0]  d0 = '0;
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ack) begin
                if (!seen) begin
                    seen = 1'b1;
                    a0 = mem_addr; w0 = mem_we; d0 = mem_wdata;
                end else begin
                    check("R12", {mem_addr[29:0], mem_we, 1'b0} ^ {a0[29:0], w0, 1'b0}, 32'h0);
                    if (w0) check("R12", {24'h0, mem_wdata}, {24'h0, d0});
                    seen = 1'b0;
                    mem_ack = 1'b1;
                    n_req++;
                    if (mem_we) begin
                        mem[mem_addr[9:0]] = mem_wdata;
                        last_wr = mem_addr;
                    end else begin
                        mem_rdata = mem[mem_addr[9:0]];
                    end
                end
            end else begin
                mem_ack = 1'b0;
            end
        end
    endtask

    // scoreboard monitor for hand-overs (R5)
    task automatic exec_monitor();
        forever begin
            @(negedge clk);
            if (exec_valid) begin
                if (q_exp.size() == 0) begin
                    check("R5/R6 unexpected exec", {exec_abort, exec_ptr[30:0]}, 32'hFFFFFFFF);
                end else begin
                    exp_t e = q_exp.pop_front();
                    check("R5 exec ptr", exec_ptr, e.ptr);
                    check("R5 exec abort", {31'h0, exec_abort}, {31'h0, e.ab});
                end
            end
        end
    endtask

    task automatic watchdog();
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic post(input logic [31:0] p, input logic [7:0] c, input logic [7:0] hs, input logic [7:0] ds);
        @(negedge clk);
        while (!cmpl_ready) @(negedge clk);
        cmpl_valid = 1'b1; cmpl_ptr = p; cmpl_code = c; cmpl_hstat = hs; cmpl_dstat = ds;
        @(negedge clk);
        cmpl_valid = 1'b0;
    endtask

    task automatic clr_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic put_narrow(input int a, input logic [7:0] c, input logic [23:0] p);
        mem[a] = c; mem[a+1] = p[23:16]; mem[a+2] = p[15:8]; mem[a+3] = p[7:0];
    endtask

    task automatic put_wide(input int a, input logic [7:0] c, input logic [31:0] p);
        mem[a] = p[7:0]; mem[a+1] = p[15:8]; mem[a+2] = p[23:16]; mem[a+3] = p[31:24];
        mem[a+4] = 8'h00; mem[a+5] = 8'h00; mem[a+6] = 8'h00; mem[a+7] = c;
    endtask

    task automatic expect_exec(input logic [31:0] p, input logic ab);
        exp_t e;
        e.ptr = p; e.ab = ab;
        q_exp.push_back(e);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        fork
            mem_model();
            exec_monitor();
            watchdog();
        join_none

        idle(3);
        check("R8 reset ready", {31'h0, cmpl_ready}, 32'h1);
        check("R11 reset irq", {31'h0, irq_loaded}, 32'h0);
        check("R5 reset exec", {31'h0, exec_valid}, 32'h0);
        rst_n = 1'b1;
        idle(2);

        // R3: doorbell and junk before init
        send(8'h02); send(8'h55);
        idle(20);
        check("R3 no request before init", n_req, 0);

        // R1: narrow ring, base 0x100, four entries
        put_narrow(32'h100, 8'h01, 24'h123456);
        put_narrow(32'h104, 8'h02, 24'hABCDEF);
        put_narrow(32'h108, 8'h07, 24'h111111);
        put_narrow(32'h10C, 8'h00, 24'h999999);
        send(8'h01); send(8'h04); send(8'h00); send(8'h01); send(8'h00);
        expect_exec(32'h00123456, 1'b0);
        expect_exec(32'h00ABCDEF, 1'b1);
        send(8'h02);
        idle(150);
        check("R1 narrow execs drained", q_exp.size(), 0);
        check("R5 entry0 freed", {24'h0, mem[32'h100]}, 32'h0);
        check("R5 entry1 freed", {24'h0, mem[32'h104]}, 32'h0);
        check("R6 odd code freed", {24'h0, mem[32'h108]}, 32'h0);
        check("R4 free entry untouched", {24'h0, mem[32'h10D]}, 32'h99);

        // R4: no reading without a doorbell; R7: wrap to index 0
        put_narrow(32'h10C, 8'h01, 24'h000010);
        put_narrow(32'h100, 8'h01, 24'h000020);
        idle(60);
        check("R4 waits for doorbell", {24'h0, mem[32'h10C]}, 32'h1);
        expect_exec(32'h00000010, 1'b0);
        expect_exec(32'h00000020, 1'b0);
        send(8'h02);
        idle(150);
        check("R7 wrap execs drained", q_exp.size(), 0);
        check("R7 wrapped entry freed", {24'h0, mem[32'h100]}, 32'h0);

        // R8/R9/R11: narrow completions into 0x110..0x11F
        post(32'h000A0B0C, 8'h01, 8'h00, 8'h00);
        check("R8 ready low after accept", {31'h0, cmpl_ready}, 32'h0);
        idle(40);
        check("R9 narrow code", {24'h0, mem[32'h110]}, 32'h1);
        check("R9 narrow ptr", {8'h0, mem[32'h111], mem[32'h112], mem[32'h113]}, 32'h000A0B0C);
        check("R9 code written last", last_wr, 32'h110);
        check("R11 irq set", {31'h0, irq_loaded}, 32'h1);
        check("R8 ready back", {31'h0, cmpl_ready}, 32'h1);
        clr_irq();
        check("R11 irq cleared", {31'h0, irq_loaded}, 32'h0);
        post(32'h1, 8'h01, 8'h0, 8'h0);
        post(32'h2, 8'h02, 8'h0, 8'h0);
        post(32'h3, 8'h03, 8'h0, 8'h0);
        idle(60);
        check("R9 last slot", {mem[32'h11C], mem[32'h11D], mem[32'h11E], mem[32'h11F]}, 32'h03000003);
        clr_irq();

        // R10: wrapped slot 0x110 still occupied
        post(32'h00445566, 8'h04, 8'h0, 8'h0);
        idle(80);
        check("R10 occupied not written", {24'h0, mem[32'h111]}, 32'h0A);
        check("R10 no irq while stalled", {31'h0, irq_loaded}, 32'h0);
        check("R8 ready low while stalled", {31'h0, cmpl_ready}, 32'h0);
        mem[32'h110] = 8'h00;
        idle(60);
        check("R9 in-ring wrap", {mem[32'h110], mem[32'h111], mem[32'h112], mem[32'h113]}, 32'h04445566);
        check("R11 irq after stall", {31'h0, irq_loaded}, 32'h1);
        clr_irq();

        // R2: wide ring, base 0x200, two entries
        put_wide(32'h200, 8'h01, 32'h12345678);
        put_wide(32'h208, 8'h02, 32'hDEADBEEF);
        send(8'h81); send(8'h02); send(8'h00); send(8'h02); send(8'h00); send(8'h00);
        expect_exec(32'h12345678, 1'b0);
        expect_exec(32'hDEADBEEF, 1'b1);
        send(8'h02);
        idle(200);
        check("R2 wide execs drained", q_exp.size(), 0);
        check("R5 wide code0 freed", {24'h0, mem[32'h207]}, 32'h0);
        check("R5 wide code1 freed", {24'h0, mem[32'h20F]}, 32'h0);

        post(32'hCAFEF00D, 8'h04, 8'h11, 8'h02);
        idle(80);
        check("R9 wide ptr", {mem[32'h213], mem[32'h212], mem[32'h211], mem[32'h210]}, 32'hCAFEF00D);
        check("R9 wide tail", {mem[32'h217], mem[32'h216], mem[32'h215], mem[32'h214]}, 32'h04000211);
        check("R9 wide code last", last_wr, 32'h217);
        check("R11 wide irq", {31'h0, irq_loaded}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule